// File: doc/BRIEF.md
# Polarity-Programmable Channel Input Combiner

This block produces the per-channel gate-on commands for a multi-channel low-side switch. Each channel has a parallel input pin. A strap input sets whether the pins are active high or active low. The pin level is first normalised to "request on" and brought into the clock domain through a short synchronizer chain. It is then combined with a data bit that the serial interface loaded. The combining operator is a stored bit selecting OR or AND. The serial interface selects it with two dedicated command codes, and the bit holds until the other code arrives or the block is reset.

The combined request is then gated by two inputs. The first is a per-channel thermal shutdown request from the diagnosis logic. The second is the active-low sleep input. Both gate without a clock, so a channel turns off in the same cycle. A low sleep level also returns the data bits, the operator and the synchronizers to their defaults at the next clock edge. The normalised, synchronised pin states are brought out for the serial read-back path.

Top module: `chan_in_combiner`

## Requirements
- R1: `in_norm[n]` equals `in_pin[n]` when `prog_pol` is 1, and equals the inverse of `in_pin[n]` when `prog_pol` is 0. It reflects a pin change after `SYNC_STAGES` (default 2) rising clock edges.
- R2: Channel n's output depends only on channel n's pin, data bit and thermal request. Bit index n is the same channel on every vector port.
- R3: With the operator set to OR, `gate_on[n]` = `in_norm[n]` OR `data[n]` (thermal request and sleep inactive).
- R4: With the operator set to AND, `gate_on[n]` = `in_norm[n]` AND `data[n]` (thermal request and sleep inactive).
- R5: A strobe with code 4'b0011 selects OR, and a strobe with code 4'b1111 selects AND. Both codes also load `cmd_data` as the data bits. The change is visible after the next rising edge.
- R6: A strobe with any code other than 4'b0000, 4'b1100, 4'b1010, 4'b0011 or 4'b1111 loads `cmd_data` and keeps the operator unchanged.
- R7: A strobe with code 4'b0000, 4'b1100 or 4'b1010 leaves both the data bits and the operator unchanged.
- R8: When `cmd_valid` is low, changes on `cmd_code` and `cmd_data` have no effect.
- R9: `therm_off[n]` high forces `gate_on[n]` low in the same cycle, whatever the inputs are.
- R10: `sleep_n` low forces all `gate_on` low in the same cycle. At the next rising edge it clears the data bits to 0, sets the operator to OR and clears `in_norm`.
- R11: After `rst` the data bits are 0 and the operator is OR, so the pins alone drive the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_n | input | 1 | Active-low sleep/reset input; outputs off and registers to defaults |
| prog_pol | input | 1 | Pin polarity strap: 1 active high, 0 active low |
| in_pin | input | N_CH | Raw parallel channel input pins |
| cmd_valid | input | 1 | Load strobe from the serial interface |
| cmd_code | input | 4 | Command code accompanying the strobe |
| cmd_data | input | N_CH | Data bits accompanying the strobe |
| therm_off | input | N_CH | Per-channel thermal shutdown request |
| in_norm | output | N_CH | Normalised, synchronised pin states for read-back |
| gate_on | output | N_CH | Per-channel gate-on command |

## Verification
The assertions check four things on every cycle: a thermal request or a low sleep level never coexists with an active output, ignored codes and idle cycles keep the data bits and operator stable, the two operator codes land in the operator register, and sleep clears the stored state. The combining truth table under both polarities and both operators only shows up in the bench's scenarios. The same holds for the latency of the synchronizer and for the rule that unlisted codes load data while keeping the operator; these are observed through the output pins.

// File: rtl/icmb_pkg.sv
package icmb_pkg;

    localparam int CMD_W = 4;

    typedef enum logic [CMD_W-1:0] {
        CMD_DIAG = 4'b0000,
        CMD_READ = 4'b1100,
        CMD_ECHO = 4'b1010,
        CMD_OR   = 4'b0011,
        CMD_AND  = 4'b1111
    } cmd_code_e;

    typedef enum logic {
        OP_OR  = 1'b0,
        OP_AND = 1'b1
    } bool_op_e;

    typedef struct packed {
        logic     load_data;
        logic     set_op;
        bool_op_e op;
    } cmd_dec_t;

    // Classify a command code into its effect on the stored state.
    function automatic cmd_dec_t decode_cmd(input logic [CMD_W-1:0] code);
        cmd_dec_t d;
        d.load_data = 1'b1;
        d.set_op    = 1'b0;
        d.op        = OP_OR;
        if (code == CMD_DIAG || code == CMD_READ || code == CMD_ECHO) begin
            d.load_data = 1'b0;
        end else if (code == CMD_OR) begin
            d.set_op = 1'b1;
            d.op     = OP_OR;
        end else if (code == CMD_AND) begin
            d.set_op = 1'b1;
            d.op     = OP_AND;
        end
        return d;
    endfunction

    function automatic logic normalise(input logic pin, input logic active_high);
        return active_high ? pin : ~pin;
    endfunction

    function automatic logic combine(input logic req, input logic dbit, input bool_op_e op);
        return (op == OP_AND) ? (req & dbit) : (req | dbit);
    endfunction

endpackage

// File: rtl/icmb_pin_sync.sv
module icmb_pin_sync
    import icmb_pkg::*;
#(
    parameter int N_CH        = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sleep_n,
    input  logic            prog_pol,
    input  logic [N_CH-1:0] in_pin,
    output logic [N_CH-1:0] norm_q
);

    logic            clr;
    logic [N_CH-1:0] norm_raw;

    assign clr = rst | ~sleep_n;

    for (genvar c = 0; c < N_CH; c++) begin : g_norm
        assign norm_raw[c] = normalise(in_pin[c], prog_pol);
    end

    if (SYNC_STAGES == 0) begin : g_bypass
        assign norm_q = norm_raw & {N_CH{sleep_n}};
    end else begin : g_chain
        logic [SYNC_STAGES-1:0][N_CH-1:0] stg;
        always_ff @(posedge clk) begin
            if (clr) begin
                stg <= '0;
            end else begin
                stg[0] <= norm_raw;
                for (int s = 1; s < SYNC_STAGES; s++) begin
                    stg[s] <= stg[s-1];
                end
            end
        end
        assign norm_q = stg[SYNC_STAGES-1];

        // R10: sleep clears the synchronised states at the next edge
        a_r10_sync_clear: assert property (@(posedge clk) disable iff (rst)
            !sleep_n |=> (norm_q == '0));
    end

endmodule

// File: rtl/icmb_cfg_reg.sv
module icmb_cfg_reg
    import icmb_pkg::*;
#(
    parameter int N_CH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sleep_n,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_code,
    input  logic [N_CH-1:0]  cmd_data,
    output logic [N_CH-1:0]  data_q,
    output bool_op_e         op_q
);

    cmd_dec_t dec;
    logic     clr;

    assign dec = decode_cmd(cmd_code);
    assign clr = rst | ~sleep_n;

    always_ff @(posedge clk) begin
        if (clr) begin
            data_q <= '0;
            op_q   <= OP_OR;
        end else if (cmd_valid) begin
            if (dec.load_data) data_q <= cmd_data;
            if (dec.set_op)    op_q   <= dec.op;
        end
    end

    // R7: data-ignoring codes leave the stored state alone
    a_r7_ignored_hold: assert property (@(posedge clk) disable iff (rst)
        (sleep_n && cmd_valid &&
         (cmd_code == CMD_DIAG || cmd_code == CMD_READ || cmd_code == CMD_ECHO))
        |=> ($stable(data_q) && $stable(op_q)));

    // R8: no strobe, no change
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (sleep_n && !cmd_valid) |=> ($stable(data_q) && $stable(op_q)));

    // R5: operator codes land in the operator register with the data
    a_r5_and_select: assert property (@(posedge clk) disable iff (rst)
        (sleep_n && cmd_valid && cmd_code == CMD_AND)
        |=> (op_q == OP_AND && data_q == $past(cmd_data)));

    a_r5_or_select: assert property (@(posedge clk) disable iff (rst)
        (sleep_n && cmd_valid && cmd_code == CMD_OR)
        |=> (op_q == OP_OR && data_q == $past(cmd_data)));

    // R10: sleep returns defaults
    a_r10_cfg_default: assert property (@(posedge clk) disable iff (rst)
        !sleep_n |=> (data_q == '0 && op_q == OP_OR));

endmodule

// File: rtl/icmb_gate.sv
module icmb_gate
    import icmb_pkg::*;
#(
    parameter int N_CH = 4
) (
    input  logic [N_CH-1:0] req,
    input  logic [N_CH-1:0] data_q,
    input  bool_op_e        op_q,
    input  logic [N_CH-1:0] therm_off,
    input  logic            sleep_n,
    output logic [N_CH-1:0] gate_on
);

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        logic merged;
        assign merged     = combine(req[c], data_q[c], op_q);
        assign gate_on[c] = merged & ~therm_off[c] & sleep_n;
    end

endmodule

// File: rtl/chan_in_combiner.sv
module chan_in_combiner
    import icmb_pkg::*;
#(
    parameter int N_CH        = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sleep_n,
    input  logic             prog_pol,
    input  logic [N_CH-1:0]  in_pin,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_code,
    input  logic [N_CH-1:0]  cmd_data,
    input  logic [N_CH-1:0]  therm_off,
    output logic [N_CH-1:0]  in_norm,
    output logic [N_CH-1:0]  gate_on
);

    logic [N_CH-1:0] data_q;
    bool_op_e        op_q;

    icmb_pin_sync #(.N_CH(N_CH), .SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .sleep_n  (sleep_n),
        .prog_pol (prog_pol),
        .in_pin   (in_pin),
        .norm_q   (in_norm)
    );

    icmb_cfg_reg #(.N_CH(N_CH)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .sleep_n   (sleep_n),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .cmd_data  (cmd_data),
        .data_q    (data_q),
        .op_q      (op_q)
    );

    icmb_gate #(.N_CH(N_CH)) u_gate (
        .req       (in_norm),
        .data_q    (data_q),
        .op_q      (op_q),
        .therm_off (therm_off),
        .sleep_n   (sleep_n),
        .gate_on   (gate_on)
    );

    // R9: a thermal request never coexists with an active output
    a_r9_therm_off: assert property (@(posedge clk) disable iff (rst)
        (therm_off & gate_on) == '0);

    // R10: sleep keeps every output off
    a_r10_sleep_off: assert property (@(posedge clk) disable iff (rst)
        !sleep_n |-> (gate_on == '0));

    // R11: out of reset, with no pin request and no load, outputs are off
    a_r11_reset_idle: assert property (@(posedge clk)
        $past(rst) && !rst && !cmd_valid && sleep_n |-> (gate_on == '0));

endmodule

// File: tb/chan_in_combiner_tb.sv
module chan_in_combiner_tb;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst;
    logic         sleep_n;
    logic         prog_pol;
    logic [N-1:0] in_pin;
    logic         cmd_valid;
    logic [3:0]   cmd_code;
    logic [N-1:0] cmd_data;
    logic [N-1:0] therm_off;
    logic [N-1:0] in_norm;
    logic [N-1:0] gate_on;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    chan_in_combiner #(.N_CH(N), .SYNC_STAGES(2)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .sleep_n   (sleep_n),
        .prog_pol  (prog_pol),
        .in_pin    (in_pin),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .cmd_data  (cmd_data),
        .therm_off (therm_off),
        .in_norm   (in_norm),
        .gate_on   (gate_on)
    );

    // {prog, and, data[3:0], pins[3:0], therm[3:0]}
    localparam logic [13:0] VEC [10] = '{
        14'b1_0_0000_1010_0000,
        14'b1_0_0101_1000_0000,
        14'b1_1_1100_1010_0000,
        14'b1_1_1111_0110_0010,
        14'b0_0_0000_1010_0000,
        14'b0_1_0111_0000_0000,
        14'b0_0_0001_1111_1000,
        14'b1_1_0000_1111_0000,
        14'b1_0_1111_0000_1111,
        14'b0_1_1010_0101_0000
    };

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_cmd(input logic [3:0] code, input logic [N-1:0] data);
        cmd_valid = 1'b1;
        cmd_code  = code;
        cmd_data  = data;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #200000;
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst = 1'b1; sleep_n = 1'b1; prog_pol = 1'b1; in_pin = '0;
        cmd_valid = 1'b0; cmd_code = '0; cmd_data = '0; therm_off = '0;
        tick(3);
        rst = 1'b0;
        tick(1);
        // R11: reset state
        check("R11 reset gate", gate_on, 4'b0000);
        check("R11 reset norm", in_norm, 4'b0000);
        in_pin = 4'b1111;
        tick(3);
        check("R11 OR default pins drive", gate_on, 4'b1111);
        in_pin = 4'b0000;
        tick(3);
        check("R11 data default zero", gate_on, 4'b0000);

        // R1 R2 R3 R4 R5: table walk
        for (int i = 0; i < 10; i++) begin
            logic         p, a;
            logic [N-1:0] d, pins, th, nrm, cmb;
            p    = VEC[i][13];
            a    = VEC[i][12];
            d    = VEC[i][11:8];
            pins = VEC[i][7:4];
            th   = VEC[i][3:0];
            prog_pol  = p;
            in_pin    = pins;
            therm_off = th;
            send_cmd(a ? 4'b1111 : 4'b0011, d);
            tick(3);
            nrm = p ? pins : ~pins;
            cmb = a ? (nrm & d) : (nrm | d);
            check("R1 polarity in_norm", in_norm, nrm);
            check(a ? "R4 R5 R2 AND vector" : "R3 R5 R2 OR vector", gate_on, cmb & ~th);
        end

        // R6: unlisted code loads data, keeps AND
        prog_pol = 1'b1; therm_off = '0; in_pin = 4'b1111;
        send_cmd(4'b1111, 4'b1111);
        send_cmd(4'b0101, 4'b0011);
        tick(3);
        check("R6 data loaded", gate_on, 4'b0011);
        in_pin = 4'b0000;
        tick(3);
        check("R6 operator kept AND", gate_on, 4'b0000);

        // R7: ignored codes
        in_pin = 4'b1111;
        send_cmd(4'b0000, 4'b1100);
        send_cmd(4'b1100, 4'b1100);
        send_cmd(4'b1010, 4'b1100);
        tick(3);
        check("R7 ignored codes keep data", gate_on, 4'b0011);
        in_pin = 4'b0000;
        tick(3);
        check("R7 ignored codes keep AND", gate_on, 4'b0000);

        // R8: no strobe
        in_pin = 4'b1111;
        cmd_code = 4'b0011; cmd_data = 4'b1111;
        tick(3);
        check("R8 idle bus no data change", gate_on, 4'b0011);
        in_pin = 4'b0000;
        tick(2);
        check("R8 idle bus keeps AND", gate_on, 4'b0000);

        // R9: thermal request immediate
        send_cmd(4'b0011, 4'b1111);
        tick(1);
        check("R9 precondition", gate_on, 4'b1111);
        #1 therm_off = 4'b0101;
        #1 check("R9 same-cycle off", gate_on, 4'b1010);
        tick(1);
        therm_off = 4'b0000;
        #1 check("R9 release", gate_on, 4'b1111);

        // R10: sleep
        tick(1);
        send_cmd(4'b1111, 4'b1111);
        in_pin = 4'b1111;
        tick(3);
        #1 sleep_n = 1'b0;
        #1 check("R10 same-cycle off", gate_on, 4'b0000);
        tick(2);
        check("R10 norm cleared", in_norm, 4'b0000);
        sleep_n = 1'b1;
        tick(3);
        check("R10 OR restored pins drive", gate_on, 4'b1111);
        in_pin = 4'b0000;
        tick(3);
        check("R10 data cleared", gate_on, 4'b0000);

        finish_run();
    end

endmodule